// File: doc/BRIEF.md
# Prioritized Interrupt Resolver

The resolver takes a pending bit, an enable bit, a type bit and a 4-bit priority for each of 64 interrupt sources. From these it produces a normal interrupt line and a fast interrupt line. A source takes part only when it is both pending and enabled. Its type bit sends it to the fast class or to the normal class. The normal line is qualified by a 5-bit threshold. The threshold value 0x1F is a bypass that lets any active normal source through.

Software acknowledges a class through a request/response handshake. The resolver then searches the class for the winning source and returns a vector word. In the same cycle it raises a clear request for that source toward the external pending storage.

The search is a three-level registered reduction tree. The first level reduces groups of eight sources, the second reduces groups of four group results, and the third produces one final result. The lines and the vector words therefore reflect the inputs as they were three clock edges earlier.

Handshake rules, one set per class:
- The requester raises its request and holds it.
- The request is accepted on the edge where both request and ready are high.
- The result valid flag pulses for exactly one cycle, on the third cycle after acceptance.
- After that pulse, ready stays low until the request has been seen low on a clock edge. A held request therefore never starts a second search.
- The result output has no back-pressure; the requester must take the word in the cycle the valid flag is high.

Top module: `prs_resolver`

## Requirements
- R1: A source is active only when its pending and enable bits are both 1. Type bit 1 makes it a fast source; type bit 0 makes it a normal source.
- R2: `fiq` equals the OR of all active fast sources, as sampled three clock edges earlier.
- R3: When `norm_mask` is 0x1F, `irq` equals the OR of all active normal sources, as sampled three clock edges earlier.
- R4: When `norm_mask` is not 0x1F, `irq` is 1 only if some active normal source has a priority strictly greater than `norm_mask`. Mask values 16 to 30 therefore keep `irq` at 0.
- R5: The priority of source n is `prio_flat[4n+3:4n]`. Source n thus sits in 32-bit word n/8 at bit offset 4*(n mod 8).
- R6: The normal result is the active normal source with the highest priority; on equal priority the higher source number wins. The word is the source number in bits 21:16 and the priority in bits 3:0, with all other bits 0.
- R7: The fast result is the lowest-numbered active fast source. The word is that source number in bits 5:0, with all other bits 0.
- R8: When no qualifying source exists, the result word is 0xFFFFFFFF and that class contributes no clear bit.
- R9: The valid flag and the clear request appear together, for one cycle, on the third cycle after acceptance. `clr_mask` bit n set means source n's pending bit is to be cleared.
- R10: `ack_*_ready` is high only when that class is idle. After a result it stays low until the request has been observed low.
- R11: Normal and fast acknowledges may be accepted in the same cycle. Both results then appear together, and `clr_mask` carries both sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| src_pend | input | 64 | pending bit per source |
| src_en | input | 64 | enable bit per source |
| src_fast | input | 64 | type per source, 1 = fast |
| prio_flat | input | 256 | 4-bit priority per source, source n at bits 4n+3:4n |
| norm_mask | input | 5 | normal threshold, 0x1F = bypass |
| ack_n_valid | input | 1 | normal acknowledge request |
| ack_n_ready | output | 1 | normal class can accept a request |
| ack_f_valid | input | 1 | fast acknowledge request |
| ack_f_ready | output | 1 | fast class can accept a request |
| irq | output | 1 | normal interrupt line |
| fiq | output | 1 | fast interrupt line |
| nvec_valid | output | 1 | one-cycle pulse, normal result ready |
| nvec_word | output | 32 | normal result word |
| fvec_valid | output | 1 | one-cycle pulse, fast result ready |
| fvec_word | output | 32 | fast result word |
| clr_mask | output | 64 | one-cycle clear request per source |

## Verification
The two functions that can coincide are the normal and the fast acknowledge. Each finishes by driving the shared `clr_mask` and its own result word in the same cycle. The bench raises both requests on the same edge, over mixed patterns and on the empty case. It then checks that both valid flags rise together on the third cycle and that each word matches an arithmetic search of its class. It also checks that `clr_mask` holds exactly the union of the two winners, or nothing for a class that returned all ones. A bench-side pending model applies the clears, so repeated dual acknowledges drain the sources, and `irq` and `fiq` are compared again after each round.

// File: rtl/prs_pkg.sv
package prs_pkg;

  parameter int unsigned SRC_N     = 64;
  parameter int unsigned PRIO_W    = 4;
  parameter int unsigned MASK_W    = 5;
  parameter int unsigned IDX_W     = $clog2(SRC_N);
  parameter int unsigned WORD_W    = 32;
  parameter int unsigned VEC_SHIFT = 16;
  parameter int unsigned PIPE_LAT  = 3;

  // one search candidate: normal winner, fast winner, threshold hit
  typedef struct packed {
    logic              nv;
    logic [PRIO_W-1:0] np;
    logic [IDX_W-1:0]  ni;
    logic              fv;
    logic [IDX_W-1:0]  fi;
    logic              hit;
  } cand_t;

  typedef enum logic [1:0] {
    ACK_IDLE = 2'd0,
    ACK_BUSY = 2'd1,
    ACK_HOLD = 2'd2
  } ack_st_e;

  // lo covers lower source numbers than hi
  function automatic cand_t cand_merge(cand_t lo, cand_t hi);
    cand_t r;
    r = lo;
    if (hi.nv && (!lo.nv || hi.np >= lo.np)) begin
      r.nv = 1'b1;
      r.np = hi.np;
      r.ni = hi.ni;
    end
    if (!lo.fv) begin
      r.fv = hi.fv;
      r.fi = hi.fi;
    end
    r.hit = lo.hit | hi.hit;
    return r;
  endfunction

  function automatic cand_t cand_make(logic p, logic e, logic t,
                                      logic [PRIO_W-1:0] pr,
                                      logic [MASK_W-1:0] mk,
                                      logic [IDX_W-1:0] id);
    cand_t c;
    c.nv  = p & e & ~t;
    c.np  = pr;
    c.ni  = id;
    c.fv  = p & e & t;
    c.fi  = id;
    c.hit = c.nv && ((mk == {MASK_W{1'b1}}) || (MASK_W'(pr) > mk));
    return c;
  endfunction

endpackage

// File: rtl/prs_reduce.sv
module prs_reduce #(
  parameter int unsigned N = 2
) (
  input  prs_pkg::cand_t [N-1:0] c_in,
  output prs_pkg::cand_t         c_out
);
  import prs_pkg::*;

  always_comb begin
    cand_t acc;
    acc = c_in[0];
    for (int i = 1; i < N; i++) begin
      acc = cand_merge(acc, c_in[i]);
    end
    c_out = acc;
  end

endmodule

// File: rtl/prs_ack_ctrl.sv
module prs_ack_ctrl #(
  parameter int unsigned LAT = prs_pkg::PIPE_LAT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  output logic res_valid
);
  import prs_pkg::*;

  ack_st_e        state;
  logic [LAT-1:0] tag;
  logic           launch;

  assign req_ready = (state == ACK_IDLE);
  assign launch    = req_valid && req_ready;
  assign res_valid = tag[LAT-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ACK_IDLE;
      tag   <= '0;
    end else begin
      tag <= {tag[LAT-2:0], launch};
      unique case (state)
        ACK_IDLE: if (launch)     state <= ACK_BUSY;
        ACK_BUSY: if (res_valid)  state <= ACK_HOLD;
        ACK_HOLD: if (!req_valid) state <= ACK_IDLE;
        default:                  state <= ACK_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/prs_resolver.sv
module prs_resolver #(
  parameter int unsigned NUM_SRC = prs_pkg::SRC_N,
  parameter int unsigned GRP     = 8,
  parameter int unsigned FAN2    = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM_SRC-1:0]                    src_pend,
  input  logic [NUM_SRC-1:0]                    src_en,
  input  logic [NUM_SRC-1:0]                    src_fast,
  input  logic [NUM_SRC*prs_pkg::PRIO_W-1:0]    prio_flat,
  input  logic [prs_pkg::MASK_W-1:0]            norm_mask,
  input  logic                                  ack_n_valid,
  output logic                                  ack_n_ready,
  input  logic                                  ack_f_valid,
  output logic                                  ack_f_ready,
  output logic                                  irq,
  output logic                                  fiq,
  output logic                                  nvec_valid,
  output logic [prs_pkg::WORD_W-1:0]            nvec_word,
  output logic                                  fvec_valid,
  output logic [prs_pkg::WORD_W-1:0]            fvec_word,
  output logic [NUM_SRC-1:0]                    clr_mask
);
  import prs_pkg::*;

  localparam int unsigned N_G1  = NUM_SRC / GRP;
  localparam int unsigned N_G2  = N_G1 / FAN2;
  localparam int unsigned HI_Z  = WORD_W - VEC_SHIFT - IDX_W;
  localparam int unsigned MID_Z = VEC_SHIFT - PRIO_W;
  localparam int unsigned FZ    = WORD_W - IDX_W;

  cand_t [N_G1-1:0] g1_d, g1_q;
  cand_t [N_G2-1:0] g2_d, g2_q;
  cand_t            fin_d, fin_q;

  // level 1: one reduction per group of sources
  for (genvar g = 0; g < N_G1; g++) begin : g_lvl1
    cand_t [GRP-1:0] leaf;
    for (genvar s = 0; s < GRP; s++) begin : g_leaf
      localparam int unsigned SI = g * GRP + s;
      assign leaf[s] = cand_make(src_pend[SI], src_en[SI], src_fast[SI],
                                 prio_flat[SI*PRIO_W +: PRIO_W], norm_mask,
                                 IDX_W'(SI));
    end
    prs_reduce #(.N(GRP)) i_red1 (.c_in(leaf), .c_out(g1_d[g]));
  end

  // level 2
  for (genvar h = 0; h < N_G2; h++) begin : g_lvl2
    prs_reduce #(.N(FAN2)) i_red2 (.c_in(g1_q[h*FAN2 +: FAN2]), .c_out(g2_d[h]));
  end

  // level 3
  prs_reduce #(.N(N_G2)) i_red3 (.c_in(g2_q), .c_out(fin_d));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g1_q  <= '0;
      g2_q  <= '0;
      fin_q <= '0;
    end else begin
      g1_q  <= g1_d;
      g2_q  <= g2_d;
      fin_q <= fin_d;
    end
  end

  // per-class acknowledge handshake, latency matched to the tree
  logic [1:0] ack_valid, ack_ready, res_valid;
  assign ack_valid = {ack_f_valid, ack_n_valid};

  for (genvar k = 0; k < 2; k++) begin : g_ack
    prs_ack_ctrl #(.LAT(PIPE_LAT)) i_ack (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(ack_valid[k]),
      .req_ready(ack_ready[k]),
      .res_valid(res_valid[k])
    );
  end

  assign ack_n_ready = ack_ready[0];
  assign ack_f_ready = ack_ready[1];
  assign nvec_valid  = res_valid[0];
  assign fvec_valid  = res_valid[1];

  assign irq = fin_q.hit;
  assign fiq = fin_q.fv;

  assign nvec_word = fin_q.nv ? {{HI_Z{1'b0}}, fin_q.ni, {MID_Z{1'b0}}, fin_q.np}
                              : {WORD_W{1'b1}};
  assign fvec_word = fin_q.fv ? {{FZ{1'b0}}, fin_q.fi} : {WORD_W{1'b1}};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
    assign clr_mask[i] = (res_valid[0] && fin_q.nv && (fin_q.ni == IDX_W'(i))) ||
                         (res_valid[1] && fin_q.fv && (fin_q.fi == IDX_W'(i)));
  end

endmodule

// File: rtl/prs_resolver_chk.sv
module prs_resolver_chk #(
  parameter int unsigned NUM_SRC = prs_pkg::SRC_N
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         ack_n_valid,
  input logic                         ack_n_ready,
  input logic                         ack_f_valid,
  input logic                         ack_f_ready,
  input logic                         nvec_valid,
  input logic [prs_pkg::WORD_W-1:0]   nvec_word,
  input logic                         fvec_valid,
  input logic [prs_pkg::WORD_W-1:0]   fvec_word,
  input logic [NUM_SRC-1:0]           clr_mask
);
  import prs_pkg::*;

  assert_clr_needs_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_mask) |-> (nvec_valid || fvec_valid));

  assert_clr_two_max_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(clr_mask) <= 2);

  assert_nvec_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nvec_valid |=> !nvec_valid);

  assert_fvec_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fvec_valid |=> !fvec_valid);

  assert_n_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ack_n_valid && ack_n_ready, 3) |-> nvec_valid);

  assert_none_no_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nvec_valid && (nvec_word == '1) && !fvec_valid) |-> (clr_mask == '0));

  assert_nclr_names_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (nvec_valid && (nvec_word != '1)) |-> clr_mask[nvec_word[VEC_SHIFT +: IDX_W]]);

  assert_fclr_names_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fvec_valid && (fvec_word != '1)) |-> clr_mask[fvec_word[IDX_W-1:0]]);

  assert_n_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (nvec_valid && ack_n_valid) |=> !ack_n_ready);

  assert_f_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fvec_valid && ack_f_valid) |=> !ack_f_ready);

endmodule

bind prs_resolver prs_resolver_chk #(.NUM_SRC(NUM_SRC)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ack_n_valid(ack_n_valid),
  .ack_n_ready(ack_n_ready),
  .ack_f_valid(ack_f_valid),
  .ack_f_ready(ack_f_ready),
  .nvec_valid (nvec_valid),
  .nvec_word  (nvec_word),
  .fvec_valid (fvec_valid),
  .fvec_word  (fvec_word),
  .clr_mask   (clr_mask)
);

// File: tb/test_prs_resolver.sv
`timescale 1ns/1ps
module test_prs_resolver;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [63:0]   pend = '0, en = '0, fast = '0;
  logic [255:0]  prio = '0;
  logic [4:0]    mask = 5'h1F;
  logic          nreq = 1'b0, freq = 1'b0;
  logic          ack_n_ready, ack_f_ready, irq, fiq, nvec_valid, fvec_valid;
  logic [31:0]   nvec_word, fvec_word;
  logic [63:0]   clr_mask;
  int            n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  prs_resolver i_prs_resolver (
    .clk(clk), .rst_n(rst_n), .src_pend(pend), .src_en(en), .src_fast(fast),
    .prio_flat(prio), .norm_mask(mask),
    .ack_n_valid(nreq), .ack_n_ready(ack_n_ready),
    .ack_f_valid(freq), .ack_f_ready(ack_f_ready),
    .irq(irq), .fiq(fiq), .nvec_valid(nvec_valid), .nvec_word(nvec_word),
    .fvec_valid(fvec_valid), .fvec_word(fvec_word), .clr_mask(clr_mask));

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [3:0] pr(int n);
    return prio[4*n +: 4];
  endfunction

  function automatic bit act_n(int n);
    return pend[n] && en[n] && !fast[n];
  endfunction

  function automatic bit act_f(int n);
    return pend[n] && en[n] && fast[n];
  endfunction

  function automatic bit exp_irq();
    bit any = 0, above = 0;
    for (int n = 0; n < 64; n++) if (act_n(n)) begin
      any = 1;
      if ({1'b0, pr(n)} > mask) above = 1;
    end
    return (mask == 5'h1F) ? any : above;
  endfunction

  function automatic bit exp_fiq();
    bit any = 0;
    for (int n = 0; n < 64; n++) if (act_f(n)) any = 1;
    return any;
  endfunction

  function automatic logic [31:0] exp_nvec();
    int best = -1, bp = -1;
    for (int n = 0; n < 64; n++)
      if (act_n(n) && int'(pr(n)) >= bp) begin best = n; bp = int'(pr(n)); end
    if (best < 0) return 32'hFFFF_FFFF;
    return (32'(best) << 16) | 32'(bp);
  endfunction

  function automatic logic [31:0] exp_fvec();
    for (int n = 0; n < 64; n++) if (act_f(n)) return 32'(n);
    return 32'hFFFF_FFFF;
  endfunction

  task automatic pattern(int seed);
    logic [63:0] x;
    x    = 64'(seed + 1) * 64'h9E37_79B9_7F4A_7C15;
    pend = x ^ (x >> 13);
    en   = {x[40:0], x[63:41]} | {x[9:0], x[63:10]};
    fast = {x[20:0], x[63:21]} & {x[50:0], x[63:51]};
    for (int n = 0; n < 64; n++) prio[4*n +: 4] = 4'((n * 5 + seed * 3) % 16);
  endtask

  task automatic check_lines(string tag);
    repeat (3) @(negedge clk);
    chk(irq == exp_irq(), {tag, " irq (R3/R4)"}, 64'(irq), 64'(exp_irq()));
    chk(fiq == exp_fiq(), "R2 fiq", 64'(fiq), 64'(exp_fiq()));
  endtask

  task automatic do_ack(bit dn, bit df, string tag);
    logic [31:0] en_w, ef_w;
    logic [63:0] eclr;
    int lat;
    en_w = exp_nvec();
    ef_w = exp_fvec();
    eclr = '0;
    if (dn && en_w != 32'hFFFF_FFFF) eclr[en_w[21:16]] = 1'b1;
    if (df && ef_w != 32'hFFFF_FFFF) eclr[ef_w[5:0]] = 1'b1;
    @(negedge clk);
    nreq = dn; freq = df; lat = 0;
    do begin @(negedge clk); lat++; end while (!(nvec_valid || fvec_valid) && lat < 10);
    chk(lat == 3, "R9 latency", 64'(lat), 64'd3);
    if (dn) chk(nvec_valid && nvec_word == en_w,
                (en_w == 32'hFFFF_FFFF) ? "R8 normal none" : {tag, " normal word R6"},
                64'(nvec_word), 64'(en_w));
    if (df) chk(fvec_valid && fvec_word == ef_w,
                (ef_w == 32'hFFFF_FFFF) ? "R8 fast none" : "R7 fast word",
                64'(fvec_word), 64'(ef_w));
    chk(clr_mask == eclr, (dn && df) ? "R11 dual clear" : "R9 clear mask", clr_mask, eclr);
    pend &= ~clr_mask;
    repeat (2) begin
      @(negedge clk);
      chk(!nvec_valid && !fvec_valid && !(dn && ack_n_ready) && !(df && ack_f_ready),
          "R10 held request", {62'd0, ack_n_ready, ack_f_ready}, 64'd0);
    end
    nreq = 1'b0; freq = 1'b0;
    repeat (2) @(negedge clk);
    chk(ack_n_ready && ack_f_ready, "R10 ready back", {62'd0, ack_n_ready, ack_f_ready}, 64'd3);
    check_lines("after ack");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!irq && !fiq && !nvec_valid && !fvec_valid && clr_mask == '0,
        "R1 reset outputs", {clr_mask[61:0], irq, fiq}, 64'd0);
    chk(ack_n_ready && ack_f_ready, "R10 reset ready", {62'd0, ack_n_ready, ack_f_ready}, 64'd3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: pending without enable, and enable without pending
    pend = '1; en = '0; fast = 64'h00FF_00FF_00FF_00FF; mask = 5'h1F;
    check_lines("R1 disabled");
    pend = '0; en = '1;
    check_lines("R1 not pending");

    // R2 R3 R4: mask sweep over several patterns
    for (int s = 0; s < 4; s++)
      for (int m = 0; m < 32; m++) begin
        @(negedge clk);
        pattern(s); mask = 5'(m);
        check_lines((m == 31) ? "R3" : "R4");
      end

    // R5 R6: priority placement per source
    for (int n = 0; n < 64; n++) begin
      @(negedge clk);
      pend = 64'd1 << n; en = '1; fast = '0; mask = 5'd0; prio = '0;
      prio[4*n +: 4] = 4'(1 + n % 15);
      check_lines("R5 placement");
      do_ack(1'b1, 1'b0, "R5");
    end

    // R6 ties toward higher number
    @(negedge clk);
    prio = '0; en = '1; fast = '0; mask = 5'h1F;
    pend = (64'd1 << 5) | (64'd1 << 20) | (64'd1 << 40) | (64'd1 << 3);
    prio[4*5 +: 4] = 4'd9; prio[4*20 +: 4] = 4'd9; prio[4*40 +: 4] = 4'd9; prio[4*3 +: 4] = 4'd2;
    for (int k = 0; k < 4; k++) do_ack(1'b1, 1'b0, "R6 tie");

    // R7 lowest fast source
    @(negedge clk);
    pend = (64'd1 << 62) | (64'd1 << 17) | (64'd1 << 33); fast = pend; en = '1;
    for (int k = 0; k < 3; k++) do_ack(1'b0, 1'b1, "R7");

    // R8 nothing qualifies
    @(negedge clk);
    pend = '0;
    do_ack(1'b1, 1'b1, "R8");

    // R11 concurrent acknowledges drain mixed patterns
    for (int s = 4; s < 10; s++) begin
      @(negedge clk);
      pattern(s); mask = 5'(s);
      for (int k = 0; k < 5; k++) do_ack(1'b1, 1'b1, "R11");
    end

    // single-class acks on further patterns
    for (int s = 10; s < 20; s++) begin
      @(negedge clk);
      pattern(s);
      do_ack(1'b1, 1'b0, "R6");
      do_ack(1'b0, 1'b1, "R7");
    end

    summary();
  end

endmodule